// File: doc/BRIEF.md
# Ping-pong descriptor DMA channel

This block is a single peripheral DMA channel that moves a stream of beats between one fixed device FIFO address and memory. Two descriptors, each holding a start address and a beat count, are used alternately. While one descriptor is being consumed, software can refill the other. A bit in the mode register shows which descriptor is current.

Software reaches the channel over a simple 32-bit register port. The mode register has two write addresses: one sets the bits written as one and the other clears them. This lets software flip single control bits without a read-modify-write. When a descriptor runs out, the channel raises that descriptor's done flag and switches to the other one. An optional interrupt follows the done flags. Clearing the run bit stops the channel cleanly, and a read-only status bit reports when it has come to rest.

Memory traffic is a request/acknowledge beat interface with one outstanding beat. A device strobe marks each completed beat.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset the mode register reads 0x00000040, with only the halted status (bit 6) set. All other registers read zero, `mem_req` is low and `irq` is low.
- R2: Offsets: 0x08 holds the device FIFO address, 0x0C and 0x10 hold descriptor 0 start and count, and 0x14 and 0x18 hold descriptor 1 start and count. A count keeps only bits 15:0 of a write, and its upper read bits are zero. Undecoded offsets read zero.
- R3: A write to offset 0x00 sets each writable mode bit written as one, and a write to 0x04 clears each one. The writable bits are 0, 2, 5, 7, 9, 10, 12, 15 and 19:16. The done flags (bits 1 and 3) can only be cleared, through 0x04. Bit 4 (current descriptor) and bit 6 (halted) cannot be written, so writing ones to bits 1, 3, 4 and 6 at offset 0x00 leaves the mode read-back unchanged.
- R4: A beat starts when the run bit (bit 5) is set, the current descriptor is enabled (bit 0 for descriptor 0, bit 2 for descriptor 1) and its count is nonzero. `mem_req` is then high, and `mem_addr` shows that descriptor's current address. The request stays high until `mem_ack`, and `dev_stb` is high in the acknowledged cycle.
- R5: Each acknowledged beat lowers the current count by one and advances the current address by the unit size. The unit size is set by bits 10:9: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes.
- R6: A descriptor completes when its last beat is acknowledged, or at once if it is enabled with a zero count while running. On completion its done flag is set, its enable is cleared and bit 4 toggles. The channel then continues on the other descriptor if that one is enabled.
- R7: If the next descriptor is not enabled, the channel waits with the run bit still set. It resumes as soon as that descriptor's enable is set.
- R8: `irq` equals bit 7 ANDed with the OR of both done flags. It stays high until both flags are cleared.
- R9: After the run bit is cleared, a beat already requested still completes, but no new beat is requested. Bit 6 reads one once no beat is pending.
- R10: `mem_wr` follows bit 12 (one means device to memory), `mem_size` follows bits 10:9 and `dev_addr` follows the FIFO address register. Bits 19:16 (device ID) and bit 15 (bank select) are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Beat request, held until acknowledged |
| mem_ack | input | 1 | Beat acknowledge |
| mem_wr | output | 1 | Beat direction, 1 = memory write |
| mem_size | output | 2 | Unit size code of the beat |
| mem_addr | output | 32 | Memory address of the current descriptor |
| dev_addr | output | 32 | Device FIFO address |
| dev_stb | output | 1 | Device strobe for a completed beat |
| irq | output | 1 | Done interrupt |

## Verification
A register write sampled at edge N is visible on `reg_rdata` and the outputs in the cycle after that edge. `mem_req` rises one cycle after run and enable are both present with a nonzero count. After each acknowledged beat there is one idle cycle before the next request. Done flags, `irq` and the bit-4 toggle appear one cycle after the last beat's acknowledge, and the halted bit rises one cycle after the acknowledge of the beat that was in flight. The bench keeps a behavioural model that steps on the same edge as the design and compares every output at the falling edge. Stimulus and acknowledges change a few nanoseconds after that falling edge, so every comparison sees settled values that belong to a single clock interval.

// File: rtl/dbdma_pkg.sv
// Shared offsets, mode bit positions and helpers for the ping-pong DMA channel.
package dbdma_pkg;
    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFF_MODE_SET = 5'h00;
    localparam logic [REG_AW-1:0] OFF_MODE_CLR = 5'h04;
    localparam logic [REG_AW-1:0] OFF_FIFO     = 5'h08;
    localparam logic [REG_AW-1:0] OFF_D0_ADDR  = 5'h0C;
    localparam logic [REG_AW-1:0] OFF_D0_CNT   = 5'h10;
    localparam logic [REG_AW-1:0] OFF_D1_ADDR  = 5'h14;
    localparam logic [REG_AW-1:0] OFF_D1_CNT   = 5'h18;

    localparam int B_EN0   = 0;
    localparam int B_DONE0 = 1;
    localparam int B_EN1   = 2;
    localparam int B_DONE1 = 3;
    localparam int B_CUR   = 4;
    localparam int B_RUN   = 5;
    localparam int B_HALT  = 6;
    localparam int B_IE    = 7;
    localparam int B_WLO   = 9;
    localparam int B_WHI   = 10;
    localparam int B_DIR   = 12;

    // Bits software may both set and clear.
    localparam logic [31:0] SW_MASK = 32'h000F_96A5;

    // Bytes per beat for a unit size code.
    function automatic logic [2:0] unit_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/dbdma_desc.sv
// One descriptor: current address and remaining count.
// Assumes software writes take priority over a same-cycle beat step.
module dbdma_desc #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          step,
    input  logic [2:0]    step_bytes,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q
);
    // Address register: load from software or advance per beat.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (addr_we) addr_q <= addr_wdata;
        else if (step)    addr_q <= addr_q + AW'(step_bytes);
    end

    // Count register: load from software or decrement per beat.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_we) cnt_q <= cnt_wdata;
        else if (step)   cnt_q <= cnt_q - CW'(1);
    end

    a_r2_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_q == $past(cnt_wdata));
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_we) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/dbdma_ctrl.sv
// Mode register (set/clear write ports) and beat sequencer.
// Assumes one outstanding beat; hardware done-set wins over a software
// clear in the same cycle, and a software enable-set wins over the
// hardware enable-clear.
module dbdma_ctrl
    import dbdma_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [31:0]   wdata,
    input  logic [CW-1:0] cnt_cur,
    input  logic          mem_ack,
    output logic [31:0]   mode,
    output logic          busy_q,
    output logic          cur_q,
    output logic          step
);
    logic [31:0] cfg_q, cfg_nxt;
    logic [1:0]  done_q, done_nxt;
    logic        run, en_cur, fin, start;

    assign run    = cfg_q[B_RUN];
    assign en_cur = cur_q ? cfg_q[B_EN1] : cfg_q[B_EN0];
    assign step   = busy_q && mem_ack;
    assign fin    = (step && cnt_cur == CW'(1)) ||
                    (!busy_q && run && en_cur && cnt_cur == '0);
    assign start  = !busy_q && run && en_cur && cnt_cur != '0;

    // Next control bits: hardware enable clear, then software set/clear.
    always_comb begin
        cfg_nxt = cfg_q;
        if (fin) cfg_nxt[cur_q ? B_EN1 : B_EN0] = 1'b0;
        if (set_we) cfg_nxt = cfg_nxt | (wdata & SW_MASK);
        if (clr_we) cfg_nxt = cfg_nxt & ~(wdata & SW_MASK);
    end

    // Next done flags: software clear, then hardware set.
    always_comb begin
        done_nxt = done_q;
        if (clr_we) done_nxt = done_nxt & ~{wdata[B_DONE1], wdata[B_DONE0]};
        if (fin) done_nxt[cur_q] = 1'b1;
    end

    // State update for control, flags, current descriptor and beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            done_q <= '0;
            cur_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            cfg_q  <= cfg_nxt;
            done_q <= done_nxt;
            if (fin) cur_q <= !cur_q;
            busy_q <= busy_q ? !mem_ack : start;
        end
    end

    // Mode read-back with hardware status folded in.
    always_comb begin
        mode          = cfg_q;
        mode[B_DONE0] = done_q[0];
        mode[B_DONE1] = done_q[1];
        mode[B_CUR]   = cur_q;
        mode[B_HALT]  = !run && !busy_q;
    end

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !mem_ack) |=> busy_q);
    a_r9_no_new_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[B_RUN] && !busy_q) |=> !busy_q);
    a_r6_switch_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q != $past(cur_q)) |-> done_q[$past(cur_q)]);
endmodule

// File: rtl/dbuf_dma_chan.sv
// Ping-pong DMA channel top: register decode, two descriptors, sequencer.
// Assumes reg_rdata is read combinationally for the presented offset.
module dbuf_dma_chan
    import dbdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [4:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    input  logic          mem_ack,
    output logic          mem_wr,
    output logic [1:0]    mem_size,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] dev_addr,
    output logic          dev_stb,
    output logic          irq
);
    localparam int NDESC = 2;

    logic [31:0]   mode;
    logic          busy, cur, step;
    logic [AW-1:0] fifo_q;
    logic [AW-1:0] d_addr [NDESC];
    logic [CW-1:0] d_cnt  [NDESC];

    dbdma_ctrl #(.CW(CW)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (reg_we && reg_addr == OFF_MODE_SET),
        .clr_we  (reg_we && reg_addr == OFF_MODE_CLR),
        .wdata   (reg_wdata),
        .cnt_cur (d_cnt[cur]),
        .mem_ack (mem_ack),
        .mode    (mode),
        .busy_q  (busy),
        .cur_q   (cur),
        .step    (step)
    );

    for (genvar i = 0; i < NDESC; i++) begin : g_desc
        localparam logic [4:0] A_OFF = (i == 0) ? OFF_D0_ADDR : OFF_D1_ADDR;
        localparam logic [4:0] C_OFF = (i == 0) ? OFF_D0_CNT  : OFF_D1_CNT;
        dbdma_desc #(.AW(AW), .CW(CW)) i_desc (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr_we    (reg_we && reg_addr == A_OFF),
            .addr_wdata (reg_wdata[AW-1:0]),
            .cnt_we     (reg_we && reg_addr == C_OFF),
            .cnt_wdata  (reg_wdata[CW-1:0]),
            .step       (step && (cur == 1'(i))),
            .step_bytes (unit_bytes(mode[B_WHI:B_WLO])),
            .addr_q     (d_addr[i]),
            .cnt_q      (d_cnt[i])
        );
    end

    // Device FIFO address register.
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_q <= '0;
        else if (reg_we && reg_addr == OFF_FIFO) fifo_q <= reg_wdata[AW-1:0];
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            OFF_MODE_SET: reg_rdata = mode;
            OFF_FIFO:     reg_rdata = 32'(fifo_q);
            OFF_D0_ADDR:  reg_rdata = 32'(d_addr[0]);
            OFF_D0_CNT:   reg_rdata = 32'(d_cnt[0]);
            OFF_D1_ADDR:  reg_rdata = 32'(d_addr[1]);
            OFF_D1_CNT:   reg_rdata = 32'(d_cnt[1]);
            default:      reg_rdata = '0;
        endcase
    end

    assign mem_req  = busy;
    assign mem_addr = d_addr[cur];
    assign mem_wr   = mode[B_DIR];
    assign mem_size = mode[B_WHI:B_WLO];
    assign dev_addr = fifo_q;
    assign dev_stb  = step;
    assign irq      = mode[B_IE] && (mode[B_DONE0] || mode[B_DONE1]);

    a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_MODE_CLR && reg_wdata[B_IE] && !reg_wdata[B_DONE0]
         && !reg_wdata[B_DONE1] && !mem_req) |=> !irq);
endmodule

// File: tb/test_dbuf_dma_chan.sv
module test_dbuf_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_wr, dev_stb, irq;
    logic        mem_ack = 1'b0;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, dev_addr;

    always #10 clk = ~clk;

    dbuf_dma_chan i_dbuf_dma_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_ack(mem_ack), .mem_wr(mem_wr), .mem_size(mem_size),
        .mem_addr(mem_addr), .dev_addr(dev_addr), .dev_stb(dev_stb), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int lat = 0;
    int waited = 0;
    bit done_run = 0;

    // Behavioural reference state.
    logic [31:0] m_cfg = '0;
    bit          m_done[2];
    bit          m_cur = 0;
    bit          m_busy = 0;
    logic [31:0] m_addr[2];
    logic [15:0] m_cnt[2];
    logic [31:0] m_fifo = '0;
    localparam logic [31:0] SWM = 32'h000F_96A5;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] m_mode();
        logic [31:0] r;
        r = m_cfg & SWM;
        r[1] = m_done[0];
        r[3] = m_done[1];
        r[4] = m_cur;
        r[6] = !m_cfg[5] && !m_busy;
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_mode();
            5'h08: return m_fifo;
            5'h0C: return m_addr[0];
            5'h10: return {16'h0, m_cnt[0]};
            5'h14: return m_addr[1];
            5'h18: return {16'h0, m_cnt[1]};
            default: return 32'h0;
        endcase
    endfunction

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = '0; m_done[0] = 0; m_done[1] = 0; m_cur = 0; m_busy = 0;
            m_addr[0] = '0; m_addr[1] = '0; m_cnt[0] = '0; m_cnt[1] = '0; m_fifo = '0;
        end else begin
            bit run, en, ack, fin, start;
            int b;
            int unsigned by;
            b = m_cur;
            run = m_cfg[5];
            en = b ? m_cfg[2] : m_cfg[0];
            ack = m_busy && mem_ack;
            fin = (ack && m_cnt[b] == 16'd1) || (!m_busy && run && en && m_cnt[b] == 16'd0);
            start = !m_busy && run && en && m_cnt[b] != 16'd0;
            by = (m_cfg[10:9] == 2'd0) ? 1 : (m_cfg[10:9] == 2'd1) ? 2 : 4;
            if (ack) begin
                m_cnt[b] = m_cnt[b] - 16'd1;
                m_addr[b] = m_addr[b] + by;
            end
            if (fin) m_cfg[b ? 2 : 0] = 1'b0;
            if (reg_we) begin
                case (reg_addr)
                    5'h00: m_cfg = m_cfg | (reg_wdata & SWM);
                    5'h04: begin
                        m_cfg = m_cfg & ~(reg_wdata & SWM);
                        if (reg_wdata[1]) m_done[0] = 0;
                        if (reg_wdata[3]) m_done[1] = 0;
                    end
                    5'h08: m_fifo = reg_wdata;
                    5'h0C: m_addr[0] = reg_wdata;
                    5'h10: m_cnt[0] = reg_wdata[15:0];
                    5'h14: m_addr[1] = reg_wdata;
                    5'h18: m_cnt[1] = reg_wdata[15:0];
                    default: ;
                endcase
            end
            if (fin) begin
                m_done[b] = 1;
                m_cur = !m_cur;
            end
            m_busy = m_busy ? !ack : start;
        end
    end

    // Per-cycle comparison against the model, at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done_run) begin
            check(reg_rdata == m_read(reg_addr), "R3 register read-back", reg_rdata, m_read(reg_addr));
            check(mem_req == m_busy, "R4 mem_req", 32'(mem_req), 32'(m_busy));
            check(mem_addr == m_addr[m_cur], "R5 mem_addr", mem_addr, m_addr[m_cur]);
            check(dev_stb == (m_busy && mem_ack), "R4 dev_stb", 32'(dev_stb), 32'(m_busy && mem_ack));
            check(irq == (m_cfg[7] && (m_done[0] || m_done[1])), "R8 irq", 32'(irq),
                  32'(m_cfg[7] && (m_done[0] || m_done[1])));
            check(mem_wr == m_cfg[12] && mem_size == m_cfg[10:9] && dev_addr == m_fifo,
                  "R10 beat attributes", {mem_wr, mem_size, dev_addr[28:0]},
                  {m_cfg[12], m_cfg[10:9], m_fifo[28:0]});
        end
        if (cyc > 100000 && !done_run) begin
            done_run = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Memory model: acknowledge after lat wait cycles.
    always @(negedge clk) begin
        #1;
        if (mem_req && waited >= lat) begin
            mem_ack = 1'b1; waited = 0;
        end else begin
            mem_ack = 1'b0;
            if (mem_req) waited++;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #2;
        reg_we = 1'b0; reg_addr = 5'h00;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); #2;
        reg_addr = a;
        @(negedge clk); #3;
        d = reg_rdata;
        reg_addr = 5'h00;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        settle(3);
        @(negedge clk); #2; rst_n = 1'b1;
        // R1 reset state
        rd(5'h00, v); check(v == 32'h40, "R1 mode after reset", v, 32'h40);
        rd(5'h10, v); check(v == 32'h0, "R1 count after reset", v, 32'h0);
        check(!mem_req && !irq, "R1 idle outputs", {mem_req, irq}, 0);
        // R2 register map and count width
        wr(5'h10, 32'hABCD_1234);
        rd(5'h10, v); check(v == 32'h1234, "R2 count keeps 16 bits", v, 32'h1234);
        wr(5'h08, 32'h4000_0010);
        rd(5'h08, v); check(v == 32'h4000_0010, "R2 fifo address", v, 32'h4000_0010);
        rd(5'h1C, v); check(v == 32'h0, "R2 undecoded offset", v, 32'h0);
        // R3 status bits not writable through the set address
        wr(5'h00, 32'h0000_005A);
        rd(5'h00, v); check(v == 32'h40, "R3 read-only bits ignored", v, 32'h40);
        wr(5'h00, 32'h0005_8000);
        rd(5'h00, v); check(v == 32'h0005_8040, "R10 device id and bank", v, 32'h0005_8040);
        wr(5'h04, 32'h0000_8000);
        rd(5'h00, v); check(v == 32'h0005_0040, "R3 clear address", v, 32'h0005_0040);
        // R4 R5 R6 two descriptors back to back, 16-bit units
        wr(5'h0C, 32'h1000); wr(5'h10, 3);
        wr(5'h14, 32'h2000); wr(5'h18, 2);
        wr(5'h00, 32'h0000_1285);
        wr(5'h00, 32'h0000_0020);
        settle(20);
        rd(5'h0C, v); check(v == 32'h1006, "R5 descriptor 0 end address", v, 32'h1006);
        rd(5'h14, v); check(v == 32'h2004, "R6 descriptor 1 end address", v, 32'h2004);
        rd(5'h00, v); check(v == 32'h0005_12AA, "R6 done flags and alternation", v, 32'h0005_12AA);
        check(irq, "R8 irq with done flags", 32'(irq), 1);
        // R7 idle then resume on enable
        wr(5'h10, 1);
        settle(4); check(!mem_req, "R7 waits while disabled", 32'(mem_req), 0);
        wr(5'h00, 32'h1);
        settle(6);
        rd(5'h0C, v); check(v == 32'h1008, "R7 resumed beat", v, 32'h1008);
        // R8 irq until both flags clear
        wr(5'h04, 32'h2); check(irq, "R8 one flag left", 32'(irq), 1);
        wr(5'h04, 32'h8); check(!irq, "R8 both flags clear", 32'(irq), 0);
        // R9 halt with a beat in flight, 32-bit units
        lat = 4;
        wr(5'h04, 32'h0000_0600); wr(5'h00, 32'h0000_0400);
        wr(5'h14, 32'h3000); wr(5'h18, 10);
        wr(5'h00, 32'h4);
        while (!mem_req) @(negedge clk);
        wr(5'h04, 32'h20);
        settle(8);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!mem_req, "R9 no beat after halt", 32'(mem_req), 0);
        end
        rd(5'h00, v); check(v[6] && !v[5], "R9 halted status", v, 32'h40);
        // R6 zero count completes at once
        lat = 0;
        wr(5'h18, 0);
        wr(5'h00, 32'h20);
        settle(3);
        rd(5'h00, v); check(v[3] && !v[2] && !v[4], "R6 zero count", v, 32'h8);
        // R5 byte units, interrupt disabled
        wr(5'h04, 32'h0000_0688);
        wr(5'h0C, 32'h5000); wr(5'h10, 2);
        wr(5'h00, 32'h1);
        settle(10);
        rd(5'h0C, v); check(v == 32'h5002, "R5 byte steps", v, 32'h5002);
        check(!irq, "R8 irq masked", 32'(irq), 0);
        done_run = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule